// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synthesizable synchronous static memory with a posted (late) write path and a half-cycle read path. At each rising clock edge it registers the address, the select, the global write strobe, the per-lane write strobes and the write data bus. A write's data does not arrive with its address. It arrives at the following rising edge, where the block pairs it with the address and lane mask it registered one cycle earlier. That address, mask and data triple goes into a one-entry write buffer. The buffer is committed to the array when the next write's data arrives, or when a deselect cycle leaves the array idle.

A read registered at a rising edge drives its word out through an output latch at the falling edge of the same cycle. If the read address matches the write held in the buffer, the buffered lanes are merged over the array contents. Writes and reads can therefore alternate on consecutive cycles in any order without a stall. An asynchronous output enable gates the data drive flag at once. A tri-stated bus is modelled as the flag low with the data forced to zero.

Two control state machines run the block. The cycle state is DESEL, READ or WRITE and records what was registered at the last rising edge. The buffer state is EMPTY or HELD. Its transitions are POST (EMPTY to HELD when write data arrives), SWAP (HELD to HELD, committing the old entry and posting the new one), DRAIN (HELD to EMPTY on a deselect with no data arriving) and KEEP (no change). A parameter chooses between a 36-bit word with four 9-bit lanes and an 18-bit word with two lanes. The depth is set by the address width.

Top module: `lwsram_core`

## Requirements
- R1: A read's address is registered at a rising edge. Its data reaches `rd_data` after the falling edge of that cycle, and not before.
- R2: Write data on `wr_data` at rising edge N+1 is written to the address and lanes registered at rising edge N.
- R3: When `glob_we` is low, only the lanes whose `lane_we` bit is set are written. Lane i occupies bits 9*i+8 down to 9*i. Every other lane keeps its previous contents.
- R4: When `glob_we` is high, all lanes are written whatever the value of `lane_we`.
- R5: A cycle with `sel` high is a write if `glob_we` or any `lane_we` bit is high, and a read otherwise. A write cycle leaves `rd_en` low after its falling edge.
- R6: A cycle with `sel` low is a deselect. No read or write starts, and `rd_en` is low after its falling edge.
- R7: `oe` acts without a clock. While `oe` is low, `rd_en` is low. Whenever `rd_en` is low, `rd_data` is zero.
- R8: A read whose address matches the buffered write returns the buffered lanes merged with the array contents of the lanes that the buffered write does not cover.
- R9: Reads and writes may follow each other on consecutive cycles in any order. Writes to the same address take effect in issue order, both through buffer swaps and through a drain on a deselect.
- R10: Reset empties the write buffer, returns the cycle state to DESEL and clears the output drive, so `rd_en` is low after reset. The array contents are not initialised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Controls and data are registered on the rising edge; read data is latched out on the falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset of the control state and the output drive |
| sel | input | 1 | Synchronous select; low makes the cycle a deselect |
| glob_we | input | 1 | Global write strobe; writes all lanes |
| lane_we | input | LANES | Per-lane write strobes |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Write data for the write registered one cycle earlier |
| oe | input | 1 | Asynchronous output enable |
| rd_data | output | DATA_W | Latched read data; zero when not driven |
| rd_en | output | 1 | Output drive flag; low means high impedance |

## Verification
A buffer that holds a stale entry, loses an entry or posts to the wrong address shows up at the next read of that address. That read can come one cycle after the write's data (forwarding) or after a deselect drain. The result is a wrong merge of lanes, visible at that read's falling edge. A cycle state that is off by one shows up one half-cycle later, as a drive flag that rises on a write or deselect cycle, or as data appearing before the falling edge. The reference sequences therefore interleave partial-lane writes, global writes, drains and repeated writes to one address, and check every cycle's output right after its falling edge.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        CYC_DESEL = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    typedef enum logic {
        BUF_EMPTY = 1'b0,
        BUF_HELD  = 1'b1
    } buf_e;

endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              glob_we,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] addr,
    output cyc_e              cyc_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  mask_q,
    output logic              data_phase,
    output logic              post_en,
    output logic              commit_en,
    output logic              buf_valid
);

    cyc_e             cyc_d;
    buf_e             buf_q;
    buf_e             buf_d;
    logic [LANES-1:0] mask_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= CYC_DESEL;
            buf_q  <= BUF_EMPTY;
            addr_q <= '0;
            mask_q <= '0;
        end else begin
            cyc_q  <= cyc_d;
            buf_q  <= buf_d;
            addr_q <= addr;
            mask_q <= mask_d;
        end
    end

    // next state: cycle kind and buffer occupancy
    always_comb begin
        if (!sel)
            cyc_d = CYC_DESEL;
        else if (glob_we || (|lane_we))
            cyc_d = CYC_WRITE;
        else
            cyc_d = CYC_READ;

        mask_d = glob_we ? {LANES{1'b1}} : lane_we;

        buf_d = buf_q;
        unique case (buf_q)
            BUF_EMPTY: begin
                if (cyc_q == CYC_WRITE)
                    buf_d = BUF_HELD;           // POST
            end
            BUF_HELD: begin
                if (cyc_q == CYC_WRITE)
                    buf_d = BUF_HELD;           // SWAP
                else if (cyc_d == CYC_DESEL)
                    buf_d = BUF_EMPTY;          // DRAIN
                else
                    buf_d = BUF_HELD;           // KEEP
            end
        endcase
    end

    // outputs
    always_comb begin
        data_phase = (cyc_q == CYC_WRITE);
        post_en    = data_phase;
        buf_valid  = (buf_q == BUF_HELD);
        commit_en  = 1'b0;
        unique case (buf_q)
            BUF_EMPTY: commit_en = 1'b0;
            BUF_HELD:  commit_en = data_phase || (cyc_d == CYC_DESEL);
        endcase
    end

endmodule

// File: rtl/lwsram_wbuf.sv
module lwsram_wbuf
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     post_en,
    input  logic [ADDR_W-1:0]        addr_in,
    input  logic [LANES-1:0]         mask_in,
    input  logic [LANES*LANE_W-1:0]  data_in,
    output logic [ADDR_W-1:0]        buf_addr,
    output logic [LANES-1:0]         buf_mask,
    output logic [LANES*LANE_W-1:0]  buf_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_addr <= '0;
            buf_mask <= '0;
            buf_data <= '0;
        end else if (post_en) begin
            buf_addr <= addr_in;
            buf_mask <= mask_in;
            buf_data <= data_in;
        end
    end

endmodule

// File: rtl/lwsram_array.sv
module lwsram_array
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [LANES-1:0]         wmask,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [LANES*LANE_W-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[l])
                mem[waddr] <= wdata[l*LANE_W +: LANE_W];
        end

        assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/lwsram_rdlatch.sv
module lwsram_rdlatch
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  cyc_e                     cyc_q,
    input  logic [ADDR_W-1:0]        raddr,
    input  logic [LANES*LANE_W-1:0]  arr_data,
    input  logic                     buf_valid,
    input  logic [ADDR_W-1:0]        buf_addr,
    input  logic [LANES-1:0]         buf_mask,
    input  logic [LANES*LANE_W-1:0]  buf_data,
    input  logic                     oe,
    output logic [LANES*LANE_W-1:0]  rd_data,
    output logic                     rd_en
);

    localparam int DATA_W = LANES * LANE_W;

    logic              hit;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] lat_q;
    logic              drv_q;

    assign hit = buf_valid && (buf_addr == raddr);

    for (genvar l = 0; l < LANES; l++) begin : g_merge
        assign merged[l*LANE_W +: LANE_W] = (hit && buf_mask[l])
            ? buf_data[l*LANE_W +: LANE_W]
            : arr_data[l*LANE_W +: LANE_W];
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
            drv_q <= 1'b0;
        end else begin
            unique case (cyc_q)
                CYC_READ: begin
                    lat_q <= merged;
                    drv_q <= 1'b1;
                end
                CYC_WRITE: drv_q <= 1'b0;
                CYC_DESEL: drv_q <= 1'b0;
                default:   drv_q <= 1'b0;
            endcase
        end
    end

    always_comb begin
        rd_en   = oe && drv_q;
        rd_data = rd_en ? lat_q : '0;
    end

endmodule

// File: rtl/lwsram_core.sv
module lwsram_core
    import lwsram_pkg::*;
#(
    parameter bit WIDE_ORG = 1'b1,
    parameter int ADDR_W   = 6,
    localparam int LANES   = WIDE_ORG ? 4 : 2,
    localparam int DATA_W  = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              glob_we,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_en
);

    cyc_e              cyc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  mask_q;
    logic              data_phase;
    logic              post_en;
    logic              commit_en;
    logic              buf_valid;
    logic [ADDR_W-1:0] buf_addr;
    logic [LANES-1:0]  buf_mask;
    logic [DATA_W-1:0] buf_data;
    logic [DATA_W-1:0] arr_data;

    lwsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .glob_we    (glob_we),
        .lane_we    (lane_we),
        .addr       (addr),
        .cyc_q      (cyc_q),
        .addr_q     (addr_q),
        .mask_q     (mask_q),
        .data_phase (data_phase),
        .post_en    (post_en),
        .commit_en  (commit_en),
        .buf_valid  (buf_valid)
    );

    lwsram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .post_en  (post_en),
        .addr_in  (addr_q),
        .mask_in  (mask_q),
        .data_in  (wr_data),
        .buf_addr (buf_addr),
        .buf_mask (buf_mask),
        .buf_data (buf_data)
    );

    lwsram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
        .clk   (clk),
        .we    (commit_en),
        .waddr (buf_addr),
        .wmask (buf_mask),
        .wdata (buf_data),
        .raddr (addr_q),
        .rdata (arr_data)
    );

    lwsram_rdlatch #(.ADDR_W(ADDR_W), .LANES(LANES)) u_rdlatch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_q     (cyc_q),
        .raddr     (addr_q),
        .arr_data  (arr_data),
        .buf_valid (buf_valid),
        .buf_addr  (buf_addr),
        .buf_mask  (buf_mask),
        .buf_data  (buf_data),
        .oe        (oe),
        .rd_data   (rd_data),
        .rd_en     (rd_en)
    );

endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic             glob_we,
    input logic [LANES-1:0] lane_we,
    input logic             oe,
    input logic             rd_en,
    input logic             data_phase,
    input logic             buf_valid,
    input logic [LANES-1:0] buf_mask
);

    logic wr_cyc;
    logic rd_cyc;
    assign wr_cyc = sel && (glob_we || (|lane_we));
    assign rd_cyc = sel && !glob_we && !(|lane_we);

    // R1: a read drives data after its falling edge when enabled
    a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_cyc) && oe) |-> rd_en);

    // R2: write data is posted to the buffer one edge after the address
    a_r2_write_posted: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_cyc, 2) |-> buf_valid);

    // R5: a write cycle does not drive the bus
    a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_cyc) |-> !rd_en);

    // R6: a deselect cycle does not drive the bus
    a_r6_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sel) |-> !rd_en);

    // R8: a held entry always covers at least one lane
    a_r8_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid |-> (buf_mask != '0));

    // R9: a deselect with no data arriving drains the buffer
    a_r9_drain_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sel && !data_phase) |-> !buf_valid);

    // R10: reset leaves the buffer empty
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r10_reset_empty: assert (!buf_valid);
        end
    end

endmodule

bind lwsram_core lwsram_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .glob_we    (glob_we),
    .lane_we    (lane_we),
    .oe         (oe),
    .rd_en      (rd_en),
    .data_phase (data_phase),
    .buf_valid  (buf_valid),
    .buf_mask   (buf_mask)
);

// File: tb/test_lwsram_core.sv
module test_lwsram_core;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    typedef struct packed {
        logic        cs;
        logic        gw;
        logic [3:0]  bw;
        logic [5:0]  ad;
        logic [35:0] wd;
        logic        ex_en;
        logic [35:0] ex_d;
    } vec_t;

    localparam logic [35:0] P  = 36'hF_FFFF_FFFF;
    localparam logic [35:0] Z  = 36'h0_0000_0000;
    localparam logic [35:0] S  = 36'h5_5555_5555;
    localparam logic [35:0] PL = 36'hF_FFFF_FE00;   // P with lane0 cleared
    localparam logic [35:0] SM = 36'h5_5557_FF55;   // S with lane1 set

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b1, 4'b0000, 6'd1, Z, 1'b0, Z},  // R4 global write a1
        '{1'b1, 1'b1, 4'b0000, 6'd2, P, 1'b0, Z},  // R2 data P for a1, write a2
        '{1'b1, 1'b0, 4'b0000, 6'd1, Z, 1'b1, P},  // R5 read a1, data Z for a2
        '{1'b1, 1'b0, 4'b0000, 6'd2, Z, 1'b1, Z},  // R8 read a2 forwarded
        '{1'b1, 1'b0, 4'b0001, 6'd1, Z, 1'b0, Z},  // R3 lane0 write a1
        '{1'b1, 1'b0, 4'b0000, 6'd1, Z, 1'b1, PL}, // R8 merged forward
        '{1'b0, 1'b0, 4'b0000, 6'd0, Z, 1'b0, Z},  // R6 deselect, drain
        '{1'b1, 1'b0, 4'b0000, 6'd1, Z, 1'b1, PL}, // R9 drained value
        '{1'b1, 1'b1, 4'b0010, 6'd3, Z, 1'b0, Z},  // R4 global with lane mask
        '{1'b1, 1'b0, 4'b0000, 6'd3, S, 1'b1, S},  // R4 all lanes written
        '{1'b1, 1'b0, 4'b0010, 6'd3, Z, 1'b0, Z},  // R9 read then write
        '{1'b1, 1'b0, 4'b0000, 6'd3, P, 1'b1, SM}, // R3 lane1 only
        '{1'b0, 1'b0, 4'b0000, 6'd0, Z, 1'b0, Z},  // R6 deselect
        '{1'b1, 1'b0, 4'b0000, 6'd2, Z, 1'b1, Z},  // R2 a2 holds its data
        '{1'b1, 1'b1, 4'b0000, 6'd4, Z, 1'b0, Z},  // R9 write a4
        '{1'b1, 1'b1, 4'b0000, 6'd4, S, 1'b0, Z},  // R9 write a4 again
        '{1'b1, 1'b0, 4'b0000, 6'd4, Z, 1'b1, Z},  // R9 last write wins
        '{1'b1, 1'b0, 4'b0000, 6'd4, Z, 1'b1, Z}   // R9 after swap
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        glob_we = 1'b0;
    logic [3:0]  lane_we = '0;
    logic [5:0]  addr = '0;
    logic [35:0] wr_data = '0;
    logic        oe = 1'b1;
    logic [35:0] rd_data;
    logic        rd_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lwsram_core i_lwsram_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .glob_we (glob_we),
        .lane_we (lane_we),
        .addr    (addr),
        .wr_data (wr_data),
        .oe      (oe),
        .rd_data (rd_data),
        .rd_en   (rd_en)
    );

    task automatic check(input string req, input logic en_exp, input logic [35:0] d_exp);
        checks++;
        if (rd_en !== en_exp || rd_data !== d_exp) begin
            fails++;
            $display("FAIL %s: en=%0b data=%h expected en=%0b data=%h",
                     req, rd_en, rd_data, en_exp, d_exp);
        end
    endtask

    task automatic drive(input vec_t v);
        sel     = v.cs;
        glob_we = v.gw;
        lane_we = v.bw;
        addr    = v.ad;
        wr_data = v.wd;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: en=%0b data=%h expected en=x data=x", rd_en, rd_data);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        check("R10 reset output off", 1'b0, Z);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i]);
            @(posedge clk);
            @(negedge clk);
            #2;
            check($sformatf("vector %0d", i), VECS[i].ex_en, VECS[i].ex_d);
        end

        // R1: data changes only after the falling edge
        drive('{1'b1, 1'b0, 4'b0000, 6'd1, Z, 1'b0, Z});
        @(posedge clk);
        #1;
        check("R1 before falling edge", 1'b1, Z);
        @(negedge clk);
        #1;
        check("R1 after falling edge", 1'b1, PL);

        // R7: asynchronous output enable
        #1;
        oe = 1'b0;
        #1;
        check("R7 oe low", 1'b0, Z);
        oe = 1'b1;
        #1;
        check("R7 oe high", 1'b1, PL);

        // R10: reset mid-run clears drive and buffer
        drive('{1'b1, 1'b1, 4'b0000, 6'd5, Z, 1'b0, Z});
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        check("R10 reset mid-run", 1'b0, Z);
        drive('{1'b0, 1'b0, 4'b0000, 6'd0, Z, 1'b0, Z});
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        drive('{1'b1, 1'b0, 4'b0000, 6'd1, Z, 1'b0, Z});
        @(posedge clk);
        @(negedge clk);
        #2;
        check("R10 array kept after reset", 1'b1, PL);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule